// File: doc/BRIEF.md
# Mixed-Cell Boundary-Scan Data Register

This block is the boundary-scan data register of a small device. It is one serial chain between `tdi` and `tdo` built from two cell types. An observe-only cell has a single capture/shift flop and never alters the signal it watches. A general cell adds an update stage, and in external-test mode that stage can drive the signal onward in place of its functional value. Bidirectional pins each take a group of three general cells (data, output enable, pull-up enable). Oscillators take a pair of cells: an observe-only cell on the clock and a general cell on the enable. Pins that double as test-access pins take no cells at all.

The layout is fixed at compile time by a packed list of group kinds, read from the least significant end of the chain, plus a count of analog control cells. The analog cells always sit above every group, in the most significant positions. The TAP state machine is external. It supplies one-cycle enables: `clock_dr` for capture/shift, `update_dr` for update, a `shift_dr` select and the `extest` mode flag. All of these are sampled on `clk`.

Top module: `bscan_mixed_reg`

## Requirements
- R1: A synchronous `rst` clears every capture/shift flop and every update stage to 0. After reset `tdo` is 0, and with `extest`=1 every general-cell output is 0.
- R2: An edge with `clock_dr`=1 and `shift_dr`=0 loads `func_in[i]` into chain bit i, for every bit.
- R3: An edge with `clock_dr`=1 and `shift_dr`=1 moves each bit one place toward bit 0 and loads `tdi` into the top bit. `tdo` always shows bit 0, so bit 0 leaves first, and after LEN shifts the first bit sent in sits in bit 0.
- R4: While `clock_dr`=0 the chain holds its contents, whatever `shift_dr`, `tdi` and `func_in` do.
- R5: An edge with `update_dr`=1 copies each general cell's chain bit into its update stage. Without `update_dr` the update stage holds its value, even while the chain shifts.
- R6: A general cell outputs its update stage when `extest`=1 and its `func_in` bit when `extest`=0.
- R7: An observe-only cell's `func_out` bit always equals its `func_in` bit, in every mode.
- R8: With the default parameters the groups run, from bit 0 up: pin group (bits 0-2), oscillator (clock observe bit 3, enable bit 4), a skipped test-access pin (no bits), observe-only (bit 5), pin group (bits 6-8) and general (bit 9). Four analog general cells follow in bits 10-13, so LEN = 14.
- R9: When `clock_dr` and `update_dr` are both high on the same edge, the update stage takes the chain contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high test reset |
| tdi | input | 1 | Serial data entering the top of the chain |
| shift_dr | input | 1 | Selects shift (1) or capture (0) for a `clock_dr` edge |
| clock_dr | input | 1 | Capture/shift enable for one edge |
| update_dr | input | 1 | Update-stage load enable for one edge |
| extest | input | 1 | External-test mode: general cells drive their update stage |
| func_in | input | LEN | Functional value arriving at each chain bit |
| func_out | output | LEN | Value passed on from each chain bit |
| tdo | output | 1 | Serial data leaving bit 0 |

## Verification
Update and capture/shift can fall on the same edge. The bench loads a known pattern, then asserts `clock_dr`, `shift_dr` and `update_dr` together for one cycle. It judges the result at two points: the driven outputs must show the pre-shift pattern, and a later shift-out must show that pattern moved down by one with the new `tdi` bit at the top. The bench also drives a reset while the update stages hold non-zero values, to show that reset wins over held state.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int MAX_GRP = 32;

    // Group kinds; each occupies a 3-bit slot of the layout map
    typedef enum logic [2:0] {
        GRP_SKIP = 3'd0,   // pin reserved for the test port, no cells
        GRP_OBS  = 3'd1,   // single observe-only cell
        GRP_GEN  = 3'd2,   // single general cell
        GRP_OSC  = 3'd3,   // observe-only clock cell, then general enable cell
        GRP_PIN  = 3'd4    // data, output enable, pull-up enable
    } grp_e;

    typedef logic [3*MAX_GRP-1:0] grp_map_t;

    typedef struct packed {
        logic shift;
        logic clock;
        logic update;
        logic extest;
    } bsr_ctl_t;

    function automatic grp_e grp_at(grp_map_t m, int idx);
        return grp_e'(m[3*idx +: 3]);
    endfunction

    function automatic int grp_width(grp_e g);
        case (g)
            GRP_OBS: return 1;
            GRP_GEN: return 1;
            GRP_OSC: return 2;
            GRP_PIN: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int grp_base(grp_map_t m, int idx);
        int s;
        s = 0;
        for (int k = 0; k < MAX_GRP; k++)
            if (k < idx) s += grp_width(grp_at(m, k));
        return s;
    endfunction

endpackage

// File: rtl/bsr_obs_cell.sv
module bsr_obs_cell
    import bsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bsr_ctl_t ctl,
    input  logic     func_i,
    input  logic     prev_i,
    output logic     q_o,
    output logic     func_o
);
    logic cap_q;

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= 1'b0;
        else if (ctl.clock)
            cap_q <= ctl.shift ? prev_i : func_i;
    end

    assign q_o    = cap_q;
    assign func_o = func_i;

    a_r4_obs_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.clock |=> $stable(cap_q));

    a_r3_obs_shift: assert property (@(posedge clk) disable iff (rst)
        (ctl.clock && ctl.shift) |=> (cap_q == $past(prev_i)));

endmodule

// File: rtl/bsr_gen_cell.sv
module bsr_gen_cell
    import bsr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bsr_ctl_t ctl,
    input  logic     func_i,
    input  logic     prev_i,
    output logic     q_o,
    output logic     func_o
);
    logic cap_q;
    logic upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
            upd_q <= 1'b0;
        end else begin
            if (ctl.clock)
                cap_q <= ctl.shift ? prev_i : func_i;
            if (ctl.update)
                upd_q <= cap_q;
        end
    end

    assign q_o    = cap_q;
    assign func_o = ctl.extest ? upd_q : func_i;

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (ctl.clock && !ctl.shift) |=> (cap_q == $past(func_i)));

    a_r3_shift: assert property (@(posedge clk) disable iff (rst)
        (ctl.clock && ctl.shift) |=> (cap_q == $past(prev_i)));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.clock |=> $stable(cap_q));

    a_r5_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.update |=> $stable(upd_q));

    a_r9_update_pre_edge: assert property (@(posedge clk) disable iff (rst)
        ctl.update |=> (upd_q == $past(cap_q)));

endmodule

// File: rtl/bsr_pin_group.sv
module bsr_pin_group
    import bsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bsr_ctl_t   ctl,
    input  logic [2:0] func_i,   // [0] data, [1] output enable, [2] pull-up enable
    input  logic       prev_i,
    output logic [2:0] q_o,
    output logic [2:0] func_o
);
    logic [3:0] link;

    assign link[3] = prev_i;

    for (genvar k = 0; k < 3; k++) begin : g_bit
        bsr_gen_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .func_i (func_i[k]),
            .prev_i (link[k+1]),
            .q_o    (link[k]),
            .func_o (func_o[k])
        );
    end

    assign q_o = link[2:0];

endmodule

// File: rtl/bscan_mixed_reg.sv
module bscan_mixed_reg
    import bsr_pkg::*;
#(
    parameter int       N_GRP   = 6,
    parameter grp_map_t GRP_MAP = grp_map_t'(18'b010_100_001_000_011_100),
    parameter int       N_ANA   = 4,
    localparam int      ANA_BASE = grp_base(GRP_MAP, N_GRP),
    localparam int      LEN      = ANA_BASE + N_ANA
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tdi,
    input  logic           shift_dr,
    input  logic           clock_dr,
    input  logic           update_dr,
    input  logic           extest,
    input  logic [LEN-1:0] func_in,
    output logic [LEN-1:0] func_out,
    output logic           tdo
);
    bsr_ctl_t     ctl;
    logic [LEN:0] chain;   // chain[i] = capture flop of bit i, chain[LEN] = tdi

    assign ctl.shift  = shift_dr;
    assign ctl.clock  = clock_dr;
    assign ctl.update = update_dr;
    assign ctl.extest = extest;

    assign chain[LEN] = tdi;
    assign tdo        = chain[0];

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam grp_e KIND = grp_at(GRP_MAP, g);
        localparam int   BASE = grp_base(GRP_MAP, g);

        if (KIND == GRP_OBS) begin : g_obs
            bsr_obs_cell u_obs (
                .clk(clk), .rst(rst), .ctl(ctl),
                .func_i(func_in[BASE]), .prev_i(chain[BASE+1]),
                .q_o(chain[BASE]), .func_o(func_out[BASE])
            );
        end else if (KIND == GRP_GEN) begin : g_gen
            bsr_gen_cell u_gen (
                .clk(clk), .rst(rst), .ctl(ctl),
                .func_i(func_in[BASE]), .prev_i(chain[BASE+1]),
                .q_o(chain[BASE]), .func_o(func_out[BASE])
            );
        end else if (KIND == GRP_OSC) begin : g_osc
            // clock line is watched only; the enable can be forced
            bsr_obs_cell u_clk (
                .clk(clk), .rst(rst), .ctl(ctl),
                .func_i(func_in[BASE]), .prev_i(chain[BASE+1]),
                .q_o(chain[BASE]), .func_o(func_out[BASE])
            );
            bsr_gen_cell u_en (
                .clk(clk), .rst(rst), .ctl(ctl),
                .func_i(func_in[BASE+1]), .prev_i(chain[BASE+2]),
                .q_o(chain[BASE+1]), .func_o(func_out[BASE+1])
            );
        end else if (KIND == GRP_PIN) begin : g_pin
            bsr_pin_group u_pin (
                .clk(clk), .rst(rst), .ctl(ctl),
                .func_i(func_in[BASE +: 3]), .prev_i(chain[BASE+3]),
                .q_o(chain[BASE +: 3]), .func_o(func_out[BASE +: 3])
            );
        end
    end

    // analog controls always occupy the top of the chain
    for (genvar a = 0; a < N_ANA; a++) begin : g_ana
        bsr_gen_cell u_ana (
            .clk(clk), .rst(rst), .ctl(ctl),
            .func_i(func_in[ANA_BASE+a]), .prev_i(chain[ANA_BASE+a+1]),
            .q_o(chain[ANA_BASE+a]), .func_o(func_out[ANA_BASE+a])
        );
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (tdo == 1'b0));

    a_r4_tdo_hold: assert property (@(posedge clk) disable iff (rst)
        !clock_dr |=> $stable(tdo));

endmodule

// File: tb/bscan_mixed_reg_bench.sv
module bscan_mixed_reg_bench;
    localparam int LEN = 14;
    localparam logic [LEN-1:0] GEN_MASK = 14'h3FD7;  // bits 3 and 5 are observe-only

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tdi = 1'b0;
    logic           shift_dr = 1'b0;
    logic           clock_dr = 1'b0;
    logic           update_dr = 1'b0;
    logic           extest = 1'b0;
    logic [LEN-1:0] func_in = '0;
    logic [LEN-1:0] func_out;
    logic           tdo;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bscan_mixed_reg u_bscan_mixed_reg (
        .clk(clk), .rst(rst), .tdi(tdi), .shift_dr(shift_dr),
        .clock_dr(clock_dr), .update_dr(update_dr), .extest(extest),
        .func_in(func_in), .func_out(func_out), .tdo(tdo)
    );

    task automatic chk(input string req, input logic [LEN-1:0] act, input logic [LEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobes_off();
        clock_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    endtask

    task automatic shift_only(input logic [LEN-1:0] sin, output logic [LEN-1:0] got);
        for (int i = 0; i < LEN; i++) begin
            got[i] = tdo;
            tdi = sin[i]; clock_dr = 1'b1; shift_dr = 1'b1;
            @(negedge clk);
        end
        strobes_off();
    endtask

    task automatic cap_shift(input logic [LEN-1:0] cap, input logic [LEN-1:0] sin,
                             output logic [LEN-1:0] got);
        func_in = cap; clock_dr = 1'b1; shift_dr = 1'b0;
        @(negedge clk);
        shift_only(sin, got);
    endtask

    task automatic pulse_update();
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    task automatic t_reset();
        logic [LEN-1:0] got;
        rst = 1'b1; func_in = '1; extest = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 tdo after reset", {13'd0, tdo}, 14'd0);
        chk("R1 general outputs zero, observe follow", func_out, ~GEN_MASK);
        shift_only('0, got);
        chk("R1 chain contents zero", got, 14'd0);
        extest = 1'b0;
    endtask

    task automatic t_capture_shift();
        logic [LEN-1:0] got;
        cap_shift(14'h2A5C, 14'h1337, got);
        chk("R2 R3 captured pattern out LSB first", got, 14'h2A5C);
        shift_only(14'h0000, got);
        chk("R3 first tdi bit lands in bit 0", got, 14'h1337);
        cap_shift(14'h0001, 14'h0000, got);
        chk("R2 walking one capture", got, 14'h0001);
        cap_shift(14'h2000, 14'h0000, got);
        chk("R2 analog MSB capture", got, 14'h2000);
    endtask

    task automatic t_update_extest();
        logic [LEN-1:0] got;
        shift_only(14'h2D69, got);
        pulse_update();
        extest = 1'b1; func_in = 14'h0000;
        @(negedge clk);
        chk("R6 R8 extest drives general cells only", func_out, 14'h2D41);
        func_in = 14'h3FFF;
        @(negedge clk);
        chk("R7 observe cells follow func_in in extest", func_out, 14'h2D69);
        extest = 1'b0; func_in = 14'h1234;
        @(negedge clk);
        chk("R6 normal mode passes func_in", func_out, 14'h1234);
    endtask

    task automatic t_hold();
        logic [LEN-1:0] got;
        extest = 1'b1; shift_dr = 1'b1; clock_dr = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tdi = i[0]; func_in = 14'h3FFF ^ 14'(i);
            @(negedge clk);
        end
        strobes_off(); func_in = 14'h0000;
        shift_only(14'h0000, got);
        chk("R4 chain held without clock_dr", got, 14'h2D69);
        @(negedge clk);
        chk("R5 update stage held across shifting", func_out, 14'h2D41);
        extest = 1'b0;
    endtask

    task automatic t_same_cycle();
        logic [LEN-1:0] got;
        shift_only(14'h0F0F, got);
        tdi = 1'b1; clock_dr = 1'b1; shift_dr = 1'b1; update_dr = 1'b1;
        @(negedge clk);
        strobes_off(); extest = 1'b1; func_in = 14'h0000;
        @(negedge clk);
        chk("R9 update takes pre-edge contents", func_out, 14'h0F07);
        shift_only(14'h3001, got);
        chk("R9 R3 concurrent shift still moved chain", got, 14'h2787);
        chk("R8 chain length is 14", {13'd0, tdo}, 14'd1);
    endtask

    task automatic t_reset_mid();
        extest = 1'b1; func_in = 14'h0000;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset clears held update stage", func_out, 14'h0000);
        chk("R1 reset clears tdo", {13'd0, tdo}, 14'd0);
        extest = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_capture_shift();
        t_update_extest();
        t_hold();
        t_same_cycle();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule